// File: doc/BRIEF.md
# 64-bit Accumulator ALU with N/Z/V/C Flags

This unit computes one accumulator operation per clock. Each cycle it takes an operation code, the 64-bit accumulator value, a 64-bit operand, a separately selected compare register and the current condition flags. On the next rising edge it presents the 64-bit result, the updated flag vector and a write-enable that tells the surrounding datapath whether the result should be written back to the accumulator.

The operation set covers add with carry, subtract with borrow, the three bitwise logic operations, logical shifts in both directions, an arithmetic right shift, rotates through carry, a low-half multiply and a compare. The flag rules are deliberately unusual and must be preserved exactly. Add and subtract derive carry by comparing the unsigned result with the operand. Overflow is a plain two-term XOR test. Shifts by 64 or more positions give zero. The arithmetic right shift only re-inserts the sign into the top bit. All outputs are registered, so there is exactly one cycle from input to result.

Top module: `alu64_core`

## Requirements
- R1: While `rst` is high at a rising edge, `result_o`, `flags_o` and `acc_we_o` become zero.
- R2: Outputs are registered with one cycle of latency. The flag vector is ordered {N,Z,V,C} (bit 3 = N, bit 0 = C). For every defined code 0 to 11, Z is 1 exactly when `result_o` is zero, and N equals `result_o[63]`.
- R3: Code 0 (add) gives A + operand + C. New C = (result < operand, unsigned). New V = (A^operand)[63] & (A^result)[63].
- R4: Code 1 (subtract) gives A − operand − (1 − C). New C = (result > operand, unsigned). V uses the same rule as add.
- R5: Codes 2, 3 and 4 give A AND, OR and XOR operand. V and C pass through unchanged.
- R6: Code 5 (logical left) and code 6 (logical right) shift A by the full operand value, and a count of 64 or more gives zero. Left sets C when any bit of A at a position of at least 64 − count is set; for count 0 or count above 64 it clears C. Logical right loads C from A[0]. V is unchanged.
- R7: Code 7 (arithmetic right) ORs the original A[63] into bit 63 of the logically right-shifted A. A count of 64 or more gives zero. C comes from A[0] and V is unchanged.
- R8: Code 8 (rotate left) gives (A << count) OR old C in bit 0, with C set as for the left shift. Code 9 (rotate right) gives (A >> count) OR old C placed at bit 64 − count; for count 0 or count above 64 no bit is placed. Rotate right sets C from A[0]. V is unchanged.
- R9: Code 10 (multiply) gives the low 64 bits of A × operand, clears V and keeps C.
- R10: Code 11 (compare) outputs compare-register − operand as `result_o` and holds `acc_we_o` low. C = (register ≥ operand, unsigned). V uses the subtract rule with the register in place of A.
- R11: `acc_we_o` is high for codes 0 to 10. For codes 12 to 15, `result_o` equals A, `flags_o` equals the input flags and `acc_we_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| acc_i | input | 64 | Accumulator value |
| opnd_i | input | 64 | Operand or shift count |
| cmp_reg_i | input | 64 | Register selected for compare |
| flags_i | input | 4 | Current flags {N,Z,V,C} |
| result_o | output | 64 | Registered result |
| acc_we_o | output | 1 | Accumulator write-enable |
| flags_o | output | 4 | Registered updated flags {N,Z,V,C} |

## Verification
The assertions relate each registered output to the inputs sampled on the previous edge. They therefore assume that every input carries a known value on every edge after reset is released and that no input changes between edges in a way that matters. They take no view on which code comes next, so a sequence of undefined codes is equally legal. The bench changes inputs only at falling edges and always drives all five data inputs with defined values, including the undefined codes 12 to 15. The first outputs it compares against the assertions' view are those after the edge on which reset was released.

// File: rtl/alu64_pkg.sv
package alu64_pkg;

  typedef enum logic [3:0] {
    OP_ADC = 4'd0,
    OP_SBC = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_XOR = 4'd4,
    OP_LSL = 4'd5,
    OP_LSR = 4'd6,
    OP_ASR = 4'd7,
    OP_ROL = 4'd8,
    OP_ROR = 4'd9,
    OP_MUL = 4'd10,
    OP_CMP = 4'd11
  } alu_op_e;

  localparam int unsigned OP_LAST = 11;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } alu_flags_t;

endpackage

// File: rtl/alu64_addsub.sv
module alu64_addsub #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  input  logic              cin,
  output logic [DATA_W-1:0] sum,
  output logic              ovf
);
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W-1:0] cin_ext;

  // a - b - (1 - cin) equals a + ~b + cin in two's complement
  assign b_eff   = sub ? ~b : b;
  assign cin_ext = {{(DATA_W-1){1'b0}}, cin};
  assign sum     = a + b_eff + cin_ext;
  // overflow rule compares against the un-inverted operand
  assign ovf     = (a[DATA_W-1] ^ b[DATA_W-1]) & (a[DATA_W-1] ^ sum[DATA_W-1]);
endmodule

// File: rtl/alu64_logic.sv
module alu64_logic
  import alu64_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res
);
  always_comb begin
    case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/alu64_shift.sv
module alu64_shift
  import alu64_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] cnt,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  localparam logic [DATA_W-1:0] WIDTH_V = DATA_W[DATA_W-1:0];

  logic [DATA_W-1:0] left_v;
  logic [DATA_W-1:0] right_v;
  logic [DATA_W-1:0] back_amt;
  logic [DATA_W-1:0] spill_bits;
  logic [DATA_W-1:0] wrap_bit;
  logic [DATA_W-1:0] sign_top;
  logic              in_range;
  logic              left_carry;

  // a full-width shift amount of DATA_W or more yields zero
  assign left_v     = a << cnt;
  assign right_v    = a >> cnt;
  assign in_range   = cnt < WIDTH_V;
  // distance back from the top; wraps for count 0 or above DATA_W
  assign back_amt   = WIDTH_V - cnt;
  assign spill_bits = a >> back_amt;
  assign left_carry = |spill_bits;
  assign wrap_bit   = {{(DATA_W-1){1'b0}}, cin} << back_amt;
  assign sign_top   = {a[DATA_W-1], {(DATA_W-1){1'b0}}};

  always_comb begin
    res  = '0;
    cout = 1'b0;
    case (op)
      OP_LSL: begin
        res  = left_v;
        cout = left_carry;
      end
      OP_LSR: begin
        res  = right_v;
        cout = a[0];
      end
      OP_ASR: begin
        res  = in_range ? (right_v | sign_top) : '0;
        cout = a[0];
      end
      OP_ROL: begin
        res  = left_v | {{(DATA_W-1){1'b0}}, cin};
        cout = left_carry;
      end
      OP_ROR: begin
        res  = right_v | wrap_bit;
        cout = a[0];
      end
      default: begin
        res  = '0;
        cout = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/alu64_core.sv
module alu64_core
  import alu64_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [DATA_W-1:0] cmp_reg_i,
  input  logic [3:0]        flags_i,
  output logic [DATA_W-1:0] result_o,
  output logic              acc_we_o,
  output logic [3:0]        flags_o
);
  alu_flags_t        fl_in;
  alu_flags_t        fl_nxt;
  logic [DATA_W-1:0] res_nxt;
  logic              we_nxt;
  logic              op_known;

  logic [DATA_W-1:0] add_sum, sub_sum, cmp_diff;
  logic              add_v, sub_v, cmp_v;
  logic [DATA_W-1:0] logic_res;
  logic [DATA_W-1:0] shift_res;
  logic              shift_c;
  logic [DATA_W-1:0] mul_res;

  assign fl_in = alu_flags_t'(flags_i);

  alu64_addsub #(.DATA_W(DATA_W)) u_add (
    .a(acc_i), .b(opnd_i), .sub(1'b0), .cin(fl_in.c),
    .sum(add_sum), .ovf(add_v)
  );

  alu64_addsub #(.DATA_W(DATA_W)) u_sub (
    .a(acc_i), .b(opnd_i), .sub(1'b1), .cin(fl_in.c),
    .sum(sub_sum), .ovf(sub_v)
  );

  // compare is a plain difference: borrow-in forced off
  alu64_addsub #(.DATA_W(DATA_W)) u_cmp (
    .a(cmp_reg_i), .b(opnd_i), .sub(1'b1), .cin(1'b1),
    .sum(cmp_diff), .ovf(cmp_v)
  );

  alu64_logic #(.DATA_W(DATA_W)) u_logic (
    .op(op_i), .a(acc_i), .b(opnd_i), .res(logic_res)
  );

  alu64_shift #(.DATA_W(DATA_W)) u_shift (
    .op(op_i), .a(acc_i), .cnt(opnd_i), .cin(fl_in.c),
    .res(shift_res), .cout(shift_c)
  );

  assign mul_res = acc_i * opnd_i;

  always_comb begin
    res_nxt  = acc_i;
    fl_nxt   = fl_in;
    we_nxt   = 1'b1;
    op_known = 1'b1;
    case (op_i)
      OP_ADC: begin
        res_nxt  = add_sum;
        fl_nxt.v = add_v;
        fl_nxt.c = add_sum < opnd_i;
      end
      OP_SBC: begin
        res_nxt  = sub_sum;
        fl_nxt.v = sub_v;
        fl_nxt.c = sub_sum > opnd_i;
      end
      OP_AND, OP_OR, OP_XOR: begin
        res_nxt = logic_res;
      end
      OP_LSL, OP_LSR, OP_ASR, OP_ROL, OP_ROR: begin
        res_nxt  = shift_res;
        fl_nxt.c = shift_c;
      end
      OP_MUL: begin
        res_nxt  = mul_res;
        fl_nxt.v = 1'b0;
      end
      OP_CMP: begin
        res_nxt  = cmp_diff;
        fl_nxt.v = cmp_v;
        fl_nxt.c = cmp_reg_i >= opnd_i;
        we_nxt   = 1'b0;
      end
      default: begin
        op_known = 1'b0;
        we_nxt   = 1'b0;
      end
    endcase
    if (op_known) begin
      fl_nxt.z = (res_nxt == '0);
      fl_nxt.n = res_nxt[DATA_W-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      acc_we_o <= 1'b0;
      flags_o  <= '0;
    end else begin
      result_o <= res_nxt;
      acc_we_o <= we_nxt;
      flags_o  <= fl_nxt;
    end
  end
endmodule

// File: rtl/alu64_core_chk.sv
module alu64_core_chk
  import alu64_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        op_i,
  input logic [DATA_W-1:0] acc_i,
  input logic [DATA_W-1:0] opnd_i,
  input logic [DATA_W-1:0] cmp_reg_i,
  input logic [3:0]        flags_i,
  input logic [DATA_W-1:0] result_o,
  input logic              acc_we_o,
  input logic [3:0]        flags_o
);
  localparam logic [DATA_W-1:0] WIDTH_V = DATA_W[DATA_W-1:0];

  // set once an edge with reset low has been seen
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (result_o == '0 && flags_o == 4'b0000 && !acc_we_o));

  assert_zero_flag_R2: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op_i) <= 4'(OP_LAST)) |-> (flags_o[2] == (result_o == '0)));

  assert_neg_flag_R2: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op_i) <= 4'(OP_LAST)) |-> (flags_o[3] == result_o[DATA_W-1]));

  assert_add_carry_R3: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op_i) == OP_ADC) |-> (flags_o[0] == (result_o < $past(opnd_i))));

  assert_logic_keeps_vc_R5: assert property (@(posedge clk) disable iff (rst)
    (armed && ($past(op_i) == OP_AND || $past(op_i) == OP_OR || $past(op_i) == OP_XOR))
    |-> (flags_o[1:0] == $past(flags_i[1:0])));

  assert_wide_shift_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (armed && ($past(op_i) == OP_LSL || $past(op_i) == OP_LSR || $past(op_i) == OP_ASR)
     && $past(opnd_i) >= WIDTH_V) |-> (result_o == '0));

  assert_mul_clears_v_R9: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op_i) == OP_MUL) |-> (!flags_o[1] && flags_o[0] == $past(flags_i[0])));

  assert_cmp_no_write_R10: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op_i) == OP_CMP) |-> (!acc_we_o && flags_o[0] == ($past(cmp_reg_i) >= $past(opnd_i))));

  assert_undefined_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op_i) > 4'(OP_LAST))
    |-> (!acc_we_o && flags_o == $past(flags_i) && result_o == $past(acc_i)));

  assert_write_defined_R11: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op_i) < OP_CMP) |-> acc_we_o);
endmodule

bind alu64_core alu64_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .op_i(op_i), .acc_i(acc_i), .opnd_i(opnd_i),
  .cmp_reg_i(cmp_reg_i), .flags_i(flags_i), .result_o(result_o),
  .acc_we_o(acc_we_o), .flags_o(flags_o)
);

// File: tb/alu64_core_test.sv
module alu64_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [3:0]   op_i = 4'd0;
  logic [W-1:0] acc_i = '0;
  logic [W-1:0] opnd_i = '0;
  logic [W-1:0] cmp_reg_i = '0;
  logic [3:0]   flags_i = 4'b0000;
  logic [W-1:0] result_o;
  logic         acc_we_o;
  logic [3:0]   flags_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu64_core #(.DATA_W(W)) uut (
    .clk(clk), .rst(rst), .op_i(op_i), .acc_i(acc_i), .opnd_i(opnd_i),
    .cmp_reg_i(cmp_reg_i), .flags_i(flags_i), .result_o(result_o),
    .acc_we_o(acc_we_o), .flags_o(flags_o)
  );

  task automatic check(string req, logic [W-1:0] er, logic [3:0] ef, logic ew);
    checks++;
    if (result_o !== er || flags_o !== ef || acc_we_o !== ew) begin
      errors++;
      $display("FAIL %s: actual res=%h flags=%b we=%b, expected res=%h flags=%b we=%b",
               req, result_o, flags_o, acc_we_o, er, ef, ew);
    end
  endtask

  // drive at falling edge, result registered at next rising edge
  task automatic apply(logic [3:0] op, logic [W-1:0] a, logic [W-1:0] b,
                       logic [W-1:0] r, logic [3:0] f);
    @(negedge clk);
    op_i = op; acc_i = a; opnd_i = b; cmp_reg_i = r; flags_i = f;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    apply(4'd0, 64'h5, 64'h7, 64'h0, 4'b0001);
    check("R1 reset", 64'h0, 4'b0000, 1'b0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_add;
    apply(4'd0, 64'd5, 64'd7, 64'd0, 4'b0001);
    check("R3 add plain", 64'd13, 4'b0000, 1'b1);
    apply(4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd0, 4'b0000);
    check("R3 add wrap", 64'h0, 4'b0111, 1'b1);
    apply(4'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 64'd0, 4'b0000);
    check("R3 R2 add to sign", 64'h8000_0000_0000_0000, 4'b1000, 1'b1);
  endtask

  task automatic t_sub;
    apply(4'd1, 64'd10, 64'd3, 64'd0, 4'b0001);
    check("R4 sub carry set", 64'd7, 4'b0001, 1'b1);
    apply(4'd1, 64'd3, 64'd3, 64'd0, 4'b0000);
    check("R4 sub borrow", 64'hFFFF_FFFF_FFFF_FFFF, 4'b1001, 1'b1);
    apply(4'd1, 64'd5, 64'd5, 64'd0, 4'b0001);
    check("R4 sub zero", 64'h0, 4'b0100, 1'b1);
  endtask

  task automatic t_logic;
    apply(4'd2, 64'hF0, 64'h0F, 64'd0, 4'b0011);
    check("R5 and", 64'h0, 4'b0111, 1'b1);
    apply(4'd3, 64'h8000_0000_0000_0000, 64'h1, 64'd0, 4'b0000);
    check("R5 or", 64'h8000_0000_0000_0001, 4'b1000, 1'b1);
    apply(4'd4, 64'h1234, 64'h1234, 64'd0, 4'b0010);
    check("R5 xor", 64'h0, 4'b0110, 1'b1);
  endtask

  task automatic t_shift;
    apply(4'd5, 64'h8000_0000_0000_0001, 64'd1, 64'd0, 4'b0000);
    check("R6 lsl by 1", 64'h2, 4'b0001, 1'b1);
    apply(4'd5, 64'h1, 64'd64, 64'd0, 4'b0000);
    check("R6 lsl by 64", 64'h0, 4'b0101, 1'b1);
    apply(4'd5, 64'h5, 64'd0, 64'd0, 4'b0011);
    check("R6 lsl by 0", 64'h5, 4'b0010, 1'b1);
    apply(4'd6, 64'h3, 64'd1, 64'd0, 4'b0000);
    check("R6 lsr by 1", 64'h1, 4'b0001, 1'b1);
    apply(4'd6, 64'hFF, 64'd100, 64'd0, 4'b0000);
    check("R6 lsr by 100", 64'h0, 4'b0101, 1'b1);
    apply(4'd7, 64'h8000_0000_0000_0010, 64'd4, 64'd0, 4'b0000);
    check("R7 asr by 4", 64'h8800_0000_0000_0001, 4'b1000, 1'b1);
    apply(4'd7, 64'h8000_0000_0000_0001, 64'd64, 64'd0, 4'b0000);
    check("R7 asr by 64", 64'h0, 4'b0101, 1'b1);
  endtask

  task automatic t_rotate;
    apply(4'd8, 64'h8000_0000_0000_0000, 64'd1, 64'd0, 4'b0001);
    check("R8 rol", 64'h1, 4'b0001, 1'b1);
    apply(4'd9, 64'h1, 64'd4, 64'd0, 4'b0001);
    check("R8 ror", 64'h1000_0000_0000_0000, 4'b0001, 1'b1);
    apply(4'd9, 64'h6, 64'd0, 64'd0, 4'b0001);
    check("R8 ror by 0", 64'h6, 4'b0000, 1'b1);
  endtask

  task automatic t_mul;
    apply(4'd10, 64'h1_0000_0000, 64'h1_0000_0003, 64'd0, 4'b0011);
    check("R9 mul low half", 64'h3_0000_0000, 4'b0001, 1'b1);
    apply(4'd10, 64'h0, 64'd5, 64'd0, 4'b0010);
    check("R9 mul zero", 64'h0, 4'b0100, 1'b1);
  endtask

  task automatic t_cmp;
    apply(4'd11, 64'd0, 64'd3, 64'd10, 4'b0000);
    check("R10 cmp greater", 64'd7, 4'b0001, 1'b0);
    apply(4'd11, 64'd99, 64'd5, 64'd5, 4'b0000);
    check("R10 cmp equal", 64'h0, 4'b0101, 1'b0);
    apply(4'd11, 64'd99, 64'd3, 64'd2, 4'b0001);
    check("R10 cmp less", 64'hFFFF_FFFF_FFFF_FFFF, 4'b1000, 1'b0);
  endtask

  task automatic t_undefined;
    apply(4'd13, 64'hABC, 64'd1, 64'd2, 4'b1010);
    check("R11 code 13 hold", 64'hABC, 4'b1010, 1'b0);
    apply(4'd15, 64'h0, 64'd0, 64'd0, 4'b0101);
    check("R11 code 15 hold", 64'h0, 4'b0101, 1'b0);
  endtask

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_shift();
    t_rotate();
    t_mul();
    t_cmp();
    t_undefined();
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    checks++;
    $display("FAIL R2 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule